// File: doc/BRIEF.md
# Shared-DAC Successive Approximation Controller

This block runs an 8-bit successive approximation conversion on a converter that has only one DAC. The same DAC normally drives the analog output from the DAC data register. When a conversion is requested, the controller takes the DAC over. It asks the analog front end to take a sample of the selected channel. It then tests one result bit per step, from the most significant bit down to the least significant bit, reading an external comparator at the end of each step. Throughout the conversion it asserts a hold signal, so the output buffer keeps showing its last value.

At the end of a conversion the controller writes the result register and gives the DAC back to the DAC data register. A single-ended conversion gives a straight binary code. A differential conversion searches in offset binary and then flips the sign bit, so the stored code is two's complement. Each step lasts a fixed, parameterised number of clock cycles, which gives the DAC time to settle before the comparator is read.

Top module: `sar_shared_dac_ctrl`

## Requirements
- R1: The search is MSB first. The step for bit k drives a DAC code made of the bits already decided plus a 1 in position k, with 0 in every lower bit. A comparator input of 1, read on the last cycle of the step, keeps bit k; a 0 clears it. The first trial code is 0x80.
- R2: A start strobe seen in idle raises busy_o at the next clock edge. sample_o is then high for exactly the first STEP_CYC cycles of the conversion, and only then.
- R3: hold_o is high in every cycle in which busy_o is high, and low in every cycle in which busy_o is low.
- R4: When idle, dac_code_o equals dac_data_i and follows any change of it. This also holds in the first idle cycle after a conversion.
- R5: A single-ended conversion stores the searched code as it is. An input at analog ground gives 0x00, and an input at full scale gives 0xFF.
- R6: A differential conversion stores the searched code with bit 7 inverted, which is two's complement. The most negative difference gives 0x80, the most positive gives 0x7F, a zero difference gives 0x00, and one step below zero gives 0xFF.
- R7: busy_o stays high for exactly 9*STEP_CYC cycles. result_o takes the new value, and done_o rises, at the same edge at which busy_o falls.
- R8: done_o is high for exactly one cycle per conversion. result_o changes only in a cycle in which done_o is high.
- R9: A start strobe while busy_o is high is ignored. This includes a strobe on the final decision cycle: busy_o stays low after the conversion ends.
- R10: After reset, result_o is 0x80, and busy_o, done_o, hold_o and sample_o are low.
- R11: diff_i is captured when a conversion starts. Changing diff_i during a conversion does not change how the result is formatted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request strobe |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| diff_i | input | 1 | 1 selects differential (two's complement) formatting |
| dac_data_i | input | 8 | Contents of the DAC data register |
| dac_code_o | output | 8 | Code driven into the shared DAC |
| hold_o | output | 1 | Output buffer hold request |
| sample_o | output | 1 | Track and hold sample request |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when the result is written |
| result_o | output | 8 | ADC data register |

## Verification
Several events fall on the same edge at the end of a conversion. The last bit decision writes the result and pulses done_o, and the DAC is handed back to the DAC data register. A new start strobe may also arrive on that last decision cycle. The bench provokes this by raising start_i on the final busy cycle of some conversions. It then checks, on the first idle cycle, that the result is right, that done_o is high, that dac_code_o equals dac_data_i again, and that busy_o stays low, which shows the late strobe did not start a second conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;

    // Phase of the conversion sequencer
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_TEST   = 2'd2
    } sar_phase_e;

    // Reset content of the result register: mid-scale
    function automatic logic [7:0] sar_reset_code();
        return 8'h80;
    endfunction

endpackage

// File: rtl/sar_step_timer.sv
// Counts the cycles of one sample or bit step and flags the last cycle
module sar_step_timer #(
    parameter int STEP_CYC = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic last_o
);
    localparam int CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEP_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s st_d, st_q;

    assign last_o = run_i && (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (!run_i || last_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sar_result_fmt.sv
// Maps the searched offset-binary code to the stored format
module sar_result_fmt #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] code_i,
    input  logic             diff_i,
    output logic [WIDTH-1:0] res_o
);
    generate
        if (WIDTH > 1) begin : g_wide
            assign res_o = {code_i[WIDTH-1] ^ diff_i, code_i[WIDTH-2:0]};
        end else begin : g_narrow
            assign res_o = code_i ^ diff_i;
        end
    endgenerate
endmodule

// File: rtl/sar_shared_dac_ctrl.sv
module sar_shared_dac_ctrl
    import sar_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int STEP_CYC = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             cmp_i,
    input  logic             diff_i,
    input  logic [WIDTH-1:0] dac_data_i,
    output logic [WIDTH-1:0] dac_code_o,
    output logic             hold_o,
    output logic             sample_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] result_o
);
    localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] RES_RST = WIDTH'(sar_reset_code() >> (8 - WIDTH));

    typedef struct packed {
        sar_phase_e       phase;
        logic [WIDTH-1:0] acc;    // bits decided so far
        logic [WIDTH-1:0] mask;   // one-hot bit under test
        logic             diff;   // captured format select
        logic [WIDTH-1:0] result;
        logic             done;
    } ctrl_s;

    ctrl_s st_d, st_q;

    logic             step_last;
    logic             running;
    logic [WIDTH-1:0] acc_kept;
    logic [WIDTH-1:0] fmt_res;

    assign running = (st_q.phase != PH_IDLE);

    sar_step_timer #(
        .STEP_CYC (STEP_CYC)
    ) i_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (running),
        .last_o (step_last)
    );

    assign acc_kept = cmp_i ? (st_q.acc | st_q.mask) : st_q.acc;

    sar_result_fmt #(
        .WIDTH (WIDTH)
    ) i_fmt (
        .code_i (acc_kept),
        .diff_i (st_q.diff),
        .res_o  (fmt_res)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase = PH_SAMPLE;
                    st_d.acc   = '0;
                    st_d.mask  = TOP_BIT;
                    st_d.diff  = diff_i;
                end
            end
            PH_SAMPLE: begin
                if (step_last) begin
                    st_d.phase = PH_TEST;
                end
            end
            PH_TEST: begin
                if (step_last) begin
                    st_d.acc = acc_kept;
                    if (st_q.mask[0]) begin
                        st_d.result = fmt_res;
                        st_d.done   = 1'b1;
                        st_d.phase  = PH_IDLE;
                    end else begin
                        st_d.mask = st_q.mask >> 1;
                    end
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.phase  <= PH_IDLE;
            st_q.acc    <= '0;
            st_q.mask   <= '0;
            st_q.diff   <= 1'b0;
            st_q.result <= RES_RST;
            st_q.done   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o     = running;
    assign hold_o     = running;
    assign sample_o   = (st_q.phase == PH_SAMPLE);
    assign dac_code_o = running ? (st_q.acc | st_q.mask) : dac_data_i;
    assign done_o     = st_q.done;
    assign result_o   = st_q.result;
endmodule

// File: rtl/sar_shared_dac_ctrl_chk.sv
module sar_shared_dac_ctrl_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [WIDTH-1:0] dac_data_i,
    input logic [WIDTH-1:0] dac_code_o,
    input logic             hold_o,
    input logic             sample_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [WIDTH-1:0] result_o
);
    // R8
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R8
    result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(result_o));

    // R7
    done_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && $past(busy_o)));

    // R3
    hold_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> hold_o);

    // R2
    sample_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> sample_o);

    // R2
    sample_inside_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_o |-> busy_o);

    // R4
    dac_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> (dac_code_o == dac_data_i));
endmodule

bind sar_shared_dac_ctrl sar_shared_dac_ctrl_chk #(
    .WIDTH (WIDTH)
) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dac_data_i (dac_data_i),
    .dac_code_o (dac_code_o),
    .hold_o     (hold_o),
    .sample_o   (sample_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o)
);

// File: tb/test_sar_shared_dac_ctrl.sv
`timescale 1ns/1ps
module test_sar_shared_dac_ctrl;
    localparam int STEP = 4;
    localparam int CONV = 9 * STEP;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       start_i = 1'b0;
    logic       cmp_i;
    logic       diff_i = 1'b0;
    logic [7:0] dac_data_i = 8'h00;
    logic [7:0] dac_code_o;
    logic       hold_o, sample_o, busy_o, done_o;
    logic [7:0] result_o;
    logic [7:0] level = 8'h00;   // analog input as an offset-binary level

    int errors = 0;
    int checks = 0;

    always #10 clk_i = ~clk_i;   // 50 MHz

    // comparator model: input at or above the DAC level
    assign cmp_i = (dac_code_o <= level);

    sar_shared_dac_ctrl #(.WIDTH(8), .STEP_CYC(STEP)) i_sar_shared_dac_ctrl (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cmp_i(cmp_i),
        .diff_i(diff_i), .dac_data_i(dac_data_i), .dac_code_o(dac_code_o),
        .hold_o(hold_o), .sample_o(sample_o), .busy_o(busy_o),
        .done_o(done_o), .result_o(result_o));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {diff, level, expected result}
    localparam logic [16:0] VEC [8] = '{
        {1'b0, 8'h00, 8'h00},   // R5 ground
        {1'b0, 8'hFF, 8'hFF},   // R5 full scale
        {1'b0, 8'h5A, 8'h5A},
        {1'b0, 8'h81, 8'h81},
        {1'b1, 8'h00, 8'h80},   // R6 most negative
        {1'b1, 8'hFF, 8'h7F},   // R6 most positive
        {1'b1, 8'h80, 8'h00},   // R6 zero
        {1'b1, 8'h7F, 8'hFF}    // R6 minus one
    };

    // Runs one conversion; late_start raises start on the last busy cycle,
    // flip_diff toggles diff_i midway.
    task automatic convert(input logic d, input logic [7:0] lvl, input logic [7:0] exp,
                           input bit late_start, input bit flip_diff, input string tag);
        int cyc;
        int hold_bad;
        level  = lvl;
        diff_i = d;
        @(negedge clk_i);
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        cyc = 0;
        hold_bad = 0;
        while (busy_o && cyc < 1000) begin
            cyc++;
            if (hold_o !== 1'b1) hold_bad++;
            if (cyc == 1) check({"R2 sample at start ", tag}, sample_o, 1'b1);
            if (cyc == STEP + 1) begin
                check({"R2 sample ended ", tag}, sample_o, 1'b0);
                check({"R1 first trial ", tag}, dac_code_o, 8'h80);
            end
            if (cyc == 2 * STEP + 1)
                check({"R1 second trial ", tag}, dac_code_o, (lvl & 8'h80) | 8'h40);
            if (cyc == 3 && !late_start) start_i = 1'b1;       // R9 mid strobe
            if (cyc == 4) start_i = 1'b0;
            if (flip_diff && cyc == 10) diff_i = ~d;           // R11
            if (late_start && cyc == CONV) start_i = 1'b1;     // R9 final cycle
            @(negedge clk_i);
            start_i = 1'b0;
        end
        check({"R7 busy length ", tag}, cyc, CONV);
        check({"R3 hold during busy ", tag}, hold_bad, 0);
        check({"R3 hold idle ", tag}, hold_o, 1'b0);
        check({"R7 done with busy fall ", tag}, done_o, 1'b1);
        check({"R5/R6 result ", tag}, result_o, exp);
        check({"R4 dac restored ", tag}, dac_code_o, dac_data_i);
        @(negedge clk_i);
        check({"R8 done one cycle ", tag}, done_o, 1'b0);
        check({"R9 no restart ", tag}, busy_o, 1'b0);
        check({"R8 result kept ", tag}, result_o, exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        dac_data_i = 8'h3C;
        repeat (3) @(negedge clk_i);
        // R10 reset state
        check("R10 result reset", result_o, 8'h80);
        check("R10 busy reset", busy_o, 1'b0);
        check("R10 done reset", done_o, 1'b0);
        check("R10 hold reset", hold_o, 1'b0);
        check("R10 sample reset", sample_o, 1'b0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R4 idle dac follows", dac_code_o, 8'h3C);
        dac_data_i = 8'hC5;
        #1;
        check("R4 idle dac change", dac_code_o, 8'hC5);

        for (int i = 0; i < 8; i++) begin
            convert(VEC[i][16], VEC[i][15:8], VEC[i][7:0], 1'b0, 1'b0, $sformatf("vec%0d", i));
        end

        // R9 start on final decision cycle
        convert(1'b0, 8'h33, 8'h33, 1'b1, 1'b0, "late start");
        repeat (3) @(negedge clk_i);
        check("R9 still idle", busy_o, 1'b0);

        // R11 diff flag changed mid conversion
        convert(1'b1, 8'h00, 8'h80, 1'b0, 1'b1, "diff flip to se");
        convert(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, "diff flip to diff");

        // R4 new DAC data after conversion is followed
        dac_data_i = 8'h11;
        #1;
        check("R4 dac after conv", dac_code_o, 8'h11);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule